// File: doc/BRIEF.md
# UART Automatic Powerdown Controller

This block runs next to a UART and decides, for the transmit half and the receive half separately, when each half may drop into a low-power state and when it has to come back. The transmit half sleeps once both its holding buffer and its shift register are empty. The receive half sleeps only when its FIFO is empty and the receiver sits idle waiting for a start bit. Each half has its own automatic-sleep enable, and a direct powerdown bit forces both halves down whatever the traffic.

Waking is driven by activity. A host write to the transmit buffer releases the transmit half in the same cycle as the write strobe, so the written byte is never lost. Any transition on the serial receive line, rising or falling, releases the receive half. The serial line and the ring-indicator modem input are each brought in through a two-stage synchronizer, and their edges are found on the synchronized values. A ring-indicator change flag keeps working while either half is asleep and holds until the host acknowledges it.

Top module: `uart_idle_pm`

## Requirements
- R1: After reset, tx_pd, rx_pd and ring_irq are all 0.
- R2: While tx_auto_en is 1 and thr_wr is 0, tx_pd rises at the first clock edge at which thr_empty and tsr_empty are both 1. If either flag is 0, tx_pd stays 0.
- R3: While the transmit half is asleep and force_pd is 0, asserting thr_wr drives tx_pd to 0 combinationally in the same cycle. tx_pd stays 0 in the following cycle.
- R4: While rx_auto_en is 1, rx_pd rises at the first clock edge at which rx_fifo_empty and rx_idle are both 1. If either one is 0, rx_pd stays 0.
- R5: A rising or a falling transition on rxd_in releases a sleeping receive half. rx_pd is still 1 after the second clock edge that follows the change and is 0 after the third.
- R6: Clearing tx_auto_en or rx_auto_en brings only that half out of powerdown at the next clock edge. The other half keeps its state.
- R7: force_pd at 1 drives tx_pd and rx_pd to 1 combinationally, even while thr_wr is 1. When force_pd returns to 0, each output shows its automatic state again, which is 0 when that half's enable is clear.
- R8: Any transition on ring_in sets ring_irq after the third clock edge that follows the change, and this holds in every powerdown state. ring_irq stays 1 until ring_ack is 1 at a clock edge. An acknowledge at the same edge as a new transition leaves ring_irq at 1.
- R9: When a wake event and a sleep condition fall in the same cycle, the wake event wins. A write with both transmit empty flags high, or a receive-line edge while the receiver is idle, leaves that half awake for one cycle before it sleeps again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_auto_en | input | 1 | Automatic sleep enable, transmit half |
| rx_auto_en | input | 1 | Automatic sleep enable, receive half |
| force_pd | input | 1 | Direct powerdown of both halves |
| thr_empty | input | 1 | Transmit holding buffer empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| thr_wr | input | 1 | Host write strobe to the transmit buffer |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| rx_idle | input | 1 | Receiver idle, waiting for a start bit |
| rxd_in | input | 1 | Raw serial receive line (asynchronous) |
| ring_in | input | 1 | Raw ring-indicator input (asynchronous) |
| ring_ack | input | 1 | Clears the ring change flag |
| tx_pd | output | 1 | Transmit half powered down |
| rx_pd | output | 1 | Receive half powered down |
| ring_irq | output | 1 | Ring-indicator change flag |

## Verification
A transmit or receive sleep register stuck in the wrong state appears on tx_pd or rx_pd one clock after the idle or enable condition that should have set or cleared it, so each entry and exit is sampled at that exact edge. A synchronizer or edge detector with the wrong depth shifts the receive wake and the ring flag by whole cycles, and the bench catches this by checking the output both one edge before the expected change and at it. A wrong priority between wake and sleep, or a lost acknowledge race, changes the output within a single cycle of the directed collision cases.

// File: rtl/uart_pm_pkg.sv
package uart_pm_pkg;

   // Default synchronizer depth for the asynchronous line inputs.
   parameter int PM_SYNC_DEFAULT = 2;

   // Bit positions of the asynchronous lines inside the shared synchronizer.
   localparam int PM_LINE_RXD   = 0;
   localparam int PM_LINE_RING  = 1;
   localparam int PM_LINE_COUNT = 2;

   typedef enum logic {
      PM_AWAKE  = 1'b0,
      PM_ASLEEP = 1'b1
   } pm_state_e;

endpackage

// File: rtl/uart_pm_sync_edge.sv
module uart_pm_sync_edge #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw,
   output logic [WIDTH-1:0] toggled
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("uart_pm_sync_edge: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_pm_sync_edge: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;
   logic [WIDTH-1:0]             prev_q;
   logic [STAGES:0]              fill_q;   // marks how far valid data has travelled

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
         fill_q  <= '0;
      end else begin
         chain_q[0] <= raw;
         for (int i = 1; i < STAGES; i++) begin
            chain_q[i] <= chain_q[i-1];
         end
         prev_q <= chain_q[LAST];
         fill_q <= {fill_q[STAGES-1:0], 1'b1};
      end
   end

   // Edges are reported only once the pipeline holds sampled data, so the
   // reset contents never look like a transition.
   assign toggled = (chain_q[LAST] ^ prev_q) & {WIDTH{fill_q[STAGES]}};

endmodule

// File: rtl/uart_pm_side.sv
module uart_pm_side
   import uart_pm_pkg::*;
#(
   parameter bit COMB_WAKE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic auto_en,
   input  logic idle,
   input  logic wake,
   output logic pd
);

   pm_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PM_AWAKE;
      end else if (!auto_en || wake) begin
         state_q <= PM_AWAKE;
      end else if (idle) begin
         state_q <= PM_ASLEEP;
      end
   end

   if (COMB_WAKE) begin : g_comb_wake
      // Wake strobe overrides the stored state in its own cycle.
      assign pd = (state_q == PM_ASLEEP) && !wake;
   end else begin : g_reg_wake
      assign pd = (state_q == PM_ASLEEP);
   end

endmodule

// File: rtl/uart_idle_pm.sv
module uart_idle_pm
   import uart_pm_pkg::*;
#(
   parameter int SYNC_STAGES = PM_SYNC_DEFAULT
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_auto_en,
   input  logic rx_auto_en,
   input  logic force_pd,
   input  logic thr_empty,
   input  logic tsr_empty,
   input  logic thr_wr,
   input  logic rx_fifo_empty,
   input  logic rx_idle,
   input  logic rxd_in,
   input  logic ring_in,
   input  logic ring_ack,
   output logic tx_pd,
   output logic rx_pd,
   output logic ring_irq
);

   localparam int LINES = PM_LINE_COUNT;

   logic [LINES-1:0] line_raw;
   logic [LINES-1:0] line_tog;
   logic             tx_auto_pd;
   logic             rx_auto_pd;
   logic             ring_q;

   assign line_raw[PM_LINE_RXD]  = rxd_in;
   assign line_raw[PM_LINE_RING] = ring_in;

   uart_pm_sync_edge #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (line_raw),
      .toggled (line_tog)
   );

   uart_pm_side #(
      .COMB_WAKE (1'b1)
   ) u_tx_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .auto_en (tx_auto_en),
      .idle    (thr_empty & tsr_empty),
      .wake    (thr_wr),
      .pd      (tx_auto_pd)
   );

   uart_pm_side #(
      .COMB_WAKE (1'b0)
   ) u_rx_side (
      .clk     (clk),
      .rst_n   (rst_n),
      .auto_en (rx_auto_en),
      .idle    (rx_fifo_empty & rx_idle),
      .wake    (line_tog[PM_LINE_RXD]),
      .pd      (rx_auto_pd)
   );

   // Ring change flag: a new edge beats a simultaneous acknowledge.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_q <= 1'b0;
      end else if (line_tog[PM_LINE_RING]) begin
         ring_q <= 1'b1;
      end else if (ring_ack) begin
         ring_q <= 1'b0;
      end
   end

   assign tx_pd    = force_pd | tx_auto_pd;
   assign rx_pd    = force_pd | rx_auto_pd;
   assign ring_irq = ring_q;

endmodule

// File: rtl/uart_idle_pm_chk.sv
module uart_idle_pm_chk (
   input logic clk,
   input logic rst_n,
   input logic tx_auto_en,
   input logic rx_auto_en,
   input logic force_pd,
   input logic thr_empty,
   input logic tsr_empty,
   input logic thr_wr,
   input logic rx_fifo_empty,
   input logic rx_idle,
   input logic ring_ack,
   input logic tx_pd,
   input logic rx_pd,
   input logic ring_irq
);

   a_r2_tx_enters_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_auto_en && thr_empty && tsr_empty && !thr_wr) |=> (tx_pd || thr_wr));

   a_r3_tx_write_wakes: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr && !force_pd) |-> !tx_pd);

   a_r4_rx_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_pd) && !force_pd && !$past(force_pd))
         |-> $past(rx_auto_en && rx_fifo_empty && rx_idle));

   a_r6_tx_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_auto_en |=> (tx_pd == force_pd));

   a_r6_rx_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_auto_en |=> (rx_pd == force_pd));

   a_r7_force_both: assert property (@(posedge clk) disable iff (!rst_n)
      force_pd |-> (tx_pd && rx_pd));

   a_r8_ring_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_irq && !ring_ack) |=> ring_irq);

endmodule

bind uart_idle_pm uart_idle_pm_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_auto_en    (tx_auto_en),
   .rx_auto_en    (rx_auto_en),
   .force_pd      (force_pd),
   .thr_empty     (thr_empty),
   .tsr_empty     (tsr_empty),
   .thr_wr        (thr_wr),
   .rx_fifo_empty (rx_fifo_empty),
   .rx_idle       (rx_idle),
   .ring_ack      (ring_ack),
   .tx_pd         (tx_pd),
   .rx_pd         (rx_pd),
   .ring_irq      (ring_irq)
);

// File: tb/uart_idle_pm_test.sv
`timescale 1ns/1ps
module uart_idle_pm_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_auto_en = 1'b0, rx_auto_en = 1'b0, force_pd = 1'b0;
   logic thr_empty = 1'b0, tsr_empty = 1'b0, thr_wr = 1'b0;
   logic rx_fifo_empty = 1'b0, rx_idle = 1'b0;
   logic rxd_in = 1'b1, ring_in = 1'b0, ring_ack = 1'b0;
   logic tx_pd, rx_pd, ring_irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   uart_idle_pm uut (
      .clk(clk), .rst_n(rst_n),
      .tx_auto_en(tx_auto_en), .rx_auto_en(rx_auto_en), .force_pd(force_pd),
      .thr_empty(thr_empty), .tsr_empty(tsr_empty), .thr_wr(thr_wr),
      .rx_fifo_empty(rx_fifo_empty), .rx_idle(rx_idle),
      .rxd_in(rxd_in), .ring_in(ring_in), .ring_ack(ring_ack),
      .tx_pd(tx_pd), .rx_pd(rx_pd), .ring_irq(ring_irq)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic quiet();
      @(negedge clk);
      tx_auto_en = 0; rx_auto_en = 0; force_pd = 0;
      thr_empty = 0; tsr_empty = 0; thr_wr = 0;
      rx_fifo_empty = 0; rx_idle = 0; ring_ack = 0;
      cyc(2);
   endtask

   task automatic t_reset_state();
      chk("R1", "tx_pd after reset", tx_pd, 1'b0);
      chk("R1", "rx_pd after reset", rx_pd, 1'b0);
      chk("R1", "ring_irq after reset", ring_irq, 1'b0);
   endtask

   task automatic t_tx_entry();
      quiet();
      tx_auto_en = 1; thr_empty = 1; tsr_empty = 0;
      cyc(2);
      chk("R2", "tx stays up, shift reg busy", tx_pd, 1'b0);
      thr_empty = 0; tsr_empty = 1;
      cyc(2);
      chk("R2", "tx stays up, holding buf busy", tx_pd, 1'b0);
      thr_empty = 1;
      #0.5 chk("R2", "tx before entry edge", tx_pd, 1'b0);
      cyc(1);
      chk("R2", "tx asleep after entry edge", tx_pd, 1'b1);
   endtask

   task automatic t_tx_wake();
      // Continues from an asleep transmit half.
      thr_wr = 1;
      #0.5 chk("R3", "tx_pd low during write strobe", tx_pd, 1'b0);
      cyc(1);
      thr_wr = 0; thr_empty = 0;
      #0.5 chk("R3", "tx_pd low cycle after write", tx_pd, 1'b0);
      cyc(2);
      chk("R3", "tx stays up while buffer full", tx_pd, 1'b0);
      thr_empty = 1;
      cyc(1);
      chk("R3", "tx sleeps again when drained", tx_pd, 1'b1);
   endtask

   task automatic t_rx_entry();
      quiet();
      rx_auto_en = 1; rx_fifo_empty = 1; rx_idle = 0;
      cyc(2);
      chk("R4", "rx up, receiver busy", rx_pd, 1'b0);
      rx_fifo_empty = 0; rx_idle = 1;
      cyc(2);
      chk("R4", "rx up, fifo not empty", rx_pd, 1'b0);
      rx_fifo_empty = 1;
      cyc(1);
      chk("R4", "rx asleep when both idle", rx_pd, 1'b1);
   endtask

   task automatic t_rx_wake();
      // Falling edge on the line, receiver goes busy.
      rxd_in = 0; rx_idle = 0;
      cyc(2);
      chk("R5", "rx still asleep after 2 edges (fall)", rx_pd, 1'b1);
      cyc(1);
      chk("R5", "rx awake after 3 edges (fall)", rx_pd, 1'b0);
      rx_idle = 1;
      cyc(1);
      chk("R5", "rx asleep again", rx_pd, 1'b1);
      rxd_in = 1; rx_idle = 0;
      cyc(2);
      chk("R5", "rx still asleep after 2 edges (rise)", rx_pd, 1'b1);
      cyc(1);
      chk("R5", "rx awake after 3 edges (rise)", rx_pd, 1'b0);
      chk("R5", "tx unaffected by line edge", tx_pd, 1'b0);
   endtask

   task automatic t_enable_clear();
      quiet();
      tx_auto_en = 1; rx_auto_en = 1;
      thr_empty = 1; tsr_empty = 1; rx_fifo_empty = 1; rx_idle = 1;
      cyc(1);
      chk("R6", "tx asleep before clear", tx_pd, 1'b1);
      chk("R6", "rx asleep before clear", rx_pd, 1'b1);
      tx_auto_en = 0;
      cyc(1);
      chk("R6", "tx up after enable clear", tx_pd, 1'b0);
      chk("R6", "rx kept asleep", rx_pd, 1'b1);
      rx_auto_en = 0;
      cyc(1);
      chk("R6", "rx up after enable clear", rx_pd, 1'b0);
   endtask

   task automatic t_force();
      quiet();
      force_pd = 1;
      #0.5 chk("R7", "force tx", tx_pd, 1'b1);
      chk("R7", "force rx", rx_pd, 1'b1);
      thr_wr = 1;
      #0.5 chk("R7", "force beats write", tx_pd, 1'b1);
      cyc(1);
      thr_wr = 0; force_pd = 0;
      #0.5 chk("R7", "release, enables clear tx", tx_pd, 1'b0);
      chk("R7", "release, enables clear rx", rx_pd, 1'b0);
      tx_auto_en = 1; thr_empty = 1; tsr_empty = 1; force_pd = 1;
      cyc(1);
      force_pd = 0;
      #0.5 chk("R7", "release shows auto sleep", tx_pd, 1'b1);
      chk("R7", "release shows rx awake", rx_pd, 1'b0);
   endtask

   task automatic t_ring();
      quiet();
      ring_in = 1;
      cyc(2);
      chk("R8", "ring not yet after 2 edges", ring_irq, 1'b0);
      cyc(1);
      chk("R8", "ring set after 3 edges", ring_irq, 1'b1);
      cyc(5);
      chk("R8", "ring held without ack", ring_irq, 1'b1);
      ring_ack = 1;
      cyc(1);
      ring_ack = 0;
      chk("R8", "ring cleared by ack", ring_irq, 1'b0);
      force_pd = 1; ring_in = 0;
      cyc(3);
      chk("R8", "ring set while powered down", ring_irq, 1'b1);
      ring_ack = 1;
      cyc(1);
      ring_ack = 0; force_pd = 0;
      ring_in = 1;
      cyc(2);
      ring_ack = 1;
      cyc(1);
      ring_ack = 0;
      chk("R8", "edge beats simultaneous ack", ring_irq, 1'b1);
      ring_ack = 1;
      cyc(1);
      ring_ack = 0;
   endtask

   task automatic t_collide();
      quiet();
      tx_auto_en = 1; thr_empty = 1; tsr_empty = 1;
      cyc(1);
      chk("R9", "tx asleep before collision", tx_pd, 1'b1);
      thr_wr = 1;
      #0.5 chk("R9", "tx up in write cycle, flags empty", tx_pd, 1'b0);
      cyc(1);
      thr_wr = 0;
      #0.5 chk("R9", "wake won the edge", tx_pd, 1'b0);
      cyc(1);
      chk("R9", "tx resleeps next edge", tx_pd, 1'b1);
      rx_auto_en = 1; rx_fifo_empty = 1; rx_idle = 1;
      cyc(1);
      chk("R9", "rx asleep before collision", rx_pd, 1'b1);
      rxd_in = 0;
      cyc(3);
      chk("R9", "rx edge wins over idle", rx_pd, 1'b0);
      cyc(1);
      chk("R9", "rx resleeps next edge", rx_pd, 1'b1);
      rxd_in = 1;
      cyc(4);
   endtask

   initial begin
      cyc(3);
      rst_n = 1;
      #0.5 t_reset_state();
      cyc(5);
      t_reset_state();
      t_tx_entry();
      t_tx_wake();
      t_rx_entry();
      t_rx_wake();
      t_enable_clear();
      t_force();
      t_ring();
      t_collide();
      quiet();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule